// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins for any logic transition and turns those transitions into interrupt requests. The pins form three groups of unequal size. The low group has eight pins. The middle group has three pins. The high group has eight pins. Indices 11 through 15 of the pin bus belong to no group. Each pin first passes through a two-flop synchronizer. A change is found by comparing the synchronized level with its value one clock earlier, so a single transition gives exactly one detection pulse.

Each pin has its own mask bit. A masked-in transition, rising or falling, sets a sticky flag for its group. Each group drives its own request line. That line is high only while the group's flag, the group's enable and the global interrupt enable are all set. A flag clears in two ways: when software writes a one to its bit, or when the interrupt logic pulses that group's acknowledge line. A small register port gives access to the control, flag and mask registers. It uses an address, write data, a write strobe and combinational read data.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: Group 0 watches pins 7..0, group 1 watches pins 10..8 and group 2 watches pins 23..16. A transition on pin 11..15 sets no flag.
- R2: Each pin's mask bit sits at the pin's offset inside its group's mask register. A transition on a pin whose mask bit is 0 leaves the flags unchanged.
- R3: A rising or falling transition on a masked-in pin sets its group's flag (flag register bit g for group g). The flag reads back as set from the third rising clock edge after the pin changes.
- R4: `irq_o[g]` is 1 exactly when flag g, control enable bit g and `gie_i` are all 1.
- R5: A one-cycle pulse on `ack_i[g]` clears flag g on that clock edge.
- R6: Writing the flag register (address 1) with a 1 in bit g clears flag g. A 0 in bit g leaves the flag unchanged.
- R7: The control register (address 0) holds enables for groups 2, 1 and 0 in bits 2, 1 and 0. Bits 7..3 read as 0 whatever is written. The mask registers sit at addresses 2, 3 and 4 for groups 0, 1 and 2 and can be read and written. Bits 7..3 of the group 1 mask always read as 0.
- R8: After reset, the enables, flags and masks all read as 0 and every request is low.
- R9: If a new transition is detected in the same cycle as an acknowledge or a write-one-to-clear for that group, the flag stays set.
- R10: One transition sets a flag only once. After it is cleared, the flag stays 0 while the pin holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous pin levels |
| gie_i | input | 1 | Global interrupt enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| ack_i | input | 3 | Per-group service acknowledge, one-cycle pulse |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The bench builds the block with its default group widths of 8, 3 and 8 bits and group bases of 0, 8 and 16. These values expose the unequal middle group, the five unused bits of its mask and the gap at pins 11..15. Two-stage synchronization gives a fixed three-edge latency from pin change to flag. This lets the bench line up a detection pulse with an acknowledge or a clear in the same cycle, which is the set-wins case.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int NUM_GROUPS = 3;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK2 = 3'd4;

  typedef logic [NUM_GROUPS-1:0] grp_vec_t;
endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] chg
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign chg = stg[STAGES-1] ^ prev;

  // R10: a pulse marks a change of the settled level, never a repeat of it
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (rst)
    (chg != '0) |=> (prev == $past(stg[STAGES-1])));
endmodule

// File: rtl/pcg_group.sv
module pcg_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  input  logic         clr,
  output logic [W-1:0] mask_o,
  output logic         flag_o
);
  logic hit;

  assign hit = |(chg & mask_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      flag_o <= 1'b0;
    end else begin
      if (mask_we) mask_o <= mask_wd;
      flag_o <= (flag_o & ~clr) | hit;
    end
  end

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_o);
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && ((chg & mask_o) == '0)) |=> !flag_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag_o);
  p_setwins_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && hit) |=> flag_o);
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl
  import pcg_pkg::*;
#(
  parameter int PIN_W   = 24,
  parameter int G0_W    = 8,
  parameter int G1_W    = 3,
  parameter int G2_W    = 8,
  parameter int G0_BASE = 0,
  parameter int G1_BASE = 8,
  parameter int G2_BASE = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic              gie_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_GROUPS-1:0] ack_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  grp_vec_t              en_q;
  grp_vec_t              flag;
  grp_vec_t              clr;
  grp_vec_t              mask_we;
  logic [DATA_W-1:0]     mask_rd [NUM_GROUPS];
  logic                  unused_gap;

  assign unused_gap = ^pin_i[G1_BASE+G1_W +: (G2_BASE-G1_BASE-G1_W)];

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (we_i && addr_i == A_CTRL) en_q <= wdata_i[NUM_GROUPS-1:0];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int W    = (g == 0) ? G0_W    : (g == 1) ? G1_W    : G2_W;
    localparam int BASE = (g == 0) ? G0_BASE : (g == 1) ? G1_BASE : G2_BASE;
    logic [W-1:0] chg;
    logic [W-1:0] mask;

    pcg_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .d(pin_i[BASE +: W]), .chg(chg));

    assign mask_we[g] = we_i && (addr_i == A_MASK0 + ADDR_W'(g));
    assign clr[g]     = ack_i[g] | (we_i && addr_i == A_FLAG && wdata_i[g]);

    pcg_group #(.W(W)) u_grp (
      .clk(clk), .rst(rst), .chg(chg), .mask_we(mask_we[g]),
      .mask_wd(wdata_i[W-1:0]), .clr(clr[g]), .mask_o(mask), .flag_o(flag[g]));

    always_comb begin
      mask_rd[g]        = '0;
      mask_rd[g][W-1:0] = mask;
    end
  end

  assign irq_o = flag & en_q & {NUM_GROUPS{gie_i}};

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[NUM_GROUPS-1:0] = en_q;
      A_FLAG:  rdata_o[NUM_GROUPS-1:0] = flag;
      A_MASK0: rdata_o = mask_rd[0];
      A_MASK1: rdata_o = mask_rd[1];
      A_MASK2: rdata_o = mask_rd[2];
      default: rdata_o = '0;
    endcase
  end

  p_gie_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !gie_i |-> (irq_o == '0));
  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~flag) == '0));
  p_ctrl_rsvd_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_i == A_CTRL) |-> (rdata_o[DATA_W-1:NUM_GROUPS] == '0));
  p_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && flag == '0));
endmodule

// File: tb/pinchg_irq_ctrl_tb.sv
module pinchg_irq_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] pin_i = '0;
  logic        gie_i = 0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 0;
  logic [7:0]  rdata_o;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pinchg_irq_ctrl u_dut (.clk(clk), .rst(rst), .pin_i(pin_i), .gie_i(gie_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o),
    .ack_i(ack_i), .irq_o(irq_o));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk); we_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic pin(int idx, logic v);
    @(negedge clk); pin_i[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); check("R8 reg", v, 8'h00); end
    check("R8 irq", {5'b0, irq_o}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R7 ctrl rsvd", v, 8'h07);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R7 mask1 upper", v, 8'h07);
    wr(3'd2, 8'hA5); rd(3'd2, v); check("R7 mask0", v, 8'hA5);
    wr(3'd4, 8'h3C); rd(3'd4, v); check("R7 mask2", v, 8'h3C);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(3'd2, 8'h01);
    pin(1, 1); rd(3'd1, v); check("R2 masked pin", v, 8'h00);
    pin(0, 1); rd(3'd1, v); check("R3 rising", v, 8'h01);
    wr(3'd1, 8'h07);
  endtask

  task automatic t_groups;
    logic [7:0] v;
    wr(3'd2, 8'hFF); wr(3'd3, 8'h07); wr(3'd4, 8'hFF);
    for (int i = 11; i < 16; i++) pin_i[i] = 1;
    repeat (4) @(negedge clk);
    rd(3'd1, v); check("R1 gap pins", v, 8'h00);
    pin(9, 1); rd(3'd1, v); check("R1 group1", v, 8'h02);
    wr(3'd1, 8'h07);
    pin(20, 1); wr(3'd1, 8'h07);
    pin(20, 0); rd(3'd1, v); check("R3 falling group2", v, 8'h04);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    pin(2, 1); pin(10, 1); rd(3'd1, v); check("R6 setup", v, 8'h07);
    wr(3'd1, 8'h02); rd(3'd1, v); check("R6 w1c", v, 8'h05);
    wr(3'd1, 8'h00); rd(3'd1, v); check("R6 write zero", v, 8'h05);
  endtask

  task automatic t_irq;
    wr(3'd0, 8'h07); gie_i = 0; @(negedge clk);
    check("R4 gie off", {5'b0, irq_o}, 8'h00);
    gie_i = 1; @(negedge clk);
    check("R4 all on", {5'b0, irq_o}, 8'h05);
    wr(3'd0, 8'h01); @(negedge clk);
    check("R4 enable", {5'b0, irq_o}, 8'h01);
  endtask

  task automatic t_ack;
    logic [7:0] v;
    @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = 0;
    rd(3'd1, v); check("R5 ack", v, 8'h04);
    check("R5 irq drop", {5'b0, irq_o}, 8'h00);
    wr(3'd1, 8'h07);
  endtask

  task automatic t_setwins;
    logic [7:0] v;
    pin(3, 1); rd(3'd1, v); check("R9 setup", v, 8'h01);
    @(negedge clk); pin_i[3] = 0;
    @(negedge clk); @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = 0;
    rd(3'd1, v); check("R9 ack vs change", v, 8'h01);
    wr(3'd1, 8'h07);
    @(negedge clk); pin_i[4] = 1;
    @(negedge clk);
    @(negedge clk); addr_i = 3'd1; wdata_i = 8'h01; we_i = 1;
    @(negedge clk); we_i = 0;
    rd(3'd1, v); check("R9 w1c vs change", v, 8'h01);
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr(3'd1, 8'h07);
    repeat (10) @(negedge clk);
    rd(3'd1, v); check("R10 no repeat", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_regs; t_mask; t_groups; t_w1c; t_irq; t_ack; t_setwins; t_single;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule